// File: doc/BRIEF.md
# Pulse-Width Remote Command Transmitter

This block turns a two-byte remote command into a pulse-width-modulated logic level. A later stage shifts that level onto a phantom supply line. All timing comes from a one-cycle frame-rate strobe, `tick_i`, and every duration is a whole number of frame periods. Each bit takes a fixed cell of 64 ticks. The pulse is high for the first part of the cell and low for the rest. A one bit has a long pulse and a short low phase; a zero bit has a short pulse and a long low phase.

To send a block, the host drives a command byte and a data byte and pulses `start_i` while the block is idle. The block captures both bytes and sends the command byte first, then the data byte straight after it, most significant bit first, with no break between them. It then holds the line low for a mandatory one-byte gap. The block stays busy until that gap has passed. At that point it raises `done_o` for one cycle and can take the next block.

Top module: `rc_pwm_tx`

## Requirements
- R1: While and after reset, `pulse_o`, `busy_o` and `done_o` are all low.
- R2: A `start_i` pulse while idle captures `cmd_i` and `data_i`. `busy_o` and `pulse_o` are both high in the next cycle, before any tick arrives.
- R3: Each bit cell lasts 64 ticks. A 1 bit is high for 56 ticks and then low for 8 ticks.
- R4: A 0 bit is high for 8 ticks and then low for 56 ticks.
- R5: The 16 cells run back to back. The command byte goes first, then the data byte, each with bit 7 first and bit 0 last.
- R6: After the 16th cell, `pulse_o` stays low and `busy_o` stays high for 512 more ticks (8 cells). A `start_i` pulse during this gap has no effect.
- R7: A `start_i` pulse during transmission is ignored. Changes on `cmd_i` and `data_i` after the capture do not alter the block being sent.
- R8: `done_o` is high for exactly one cycle: the first cycle in which `busy_o` is low after a block. A `start_i` pulse in that cycle is accepted.
- R9: `pulse_o` changes level only in the cycle after a tick, except when it rises in the cycle after an accepted start. No pulse lasts more than 56 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle frame-rate strobe |
| start_i | input | 1 | Begin a block (taken only when idle) |
| cmd_i | input | 8 | Command byte, sent first |
| data_i | input | 8 | Data byte, sent second |
| pulse_o | output | 1 | PWM level, high during each pulse |
| busy_o | output | 1 | High from capture until the gap ends |
| done_o | output | 1 | One-cycle pulse when the gap ends |

## Verification
The hardest situation to reach from the ports is a start request that falls inside the trailing gap. At that moment the line has been low for hundreds of ticks and looks idle, but the block must still refuse the request. The bench counts cycles from a known start, issues a start with different bytes about 100 ticks into the gap, and checks that `busy_o` is still high there. The scoreboard then checks that no extra cells appear. A second block is launched in the very cycle `done_o` is high, which exercises the boundary between the gap and idle.

// File: rtl/rc_pwm_pkg.sv
package rc_pwm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/rc_cell_timer.sv
module rc_cell_timer #(
  parameter int CELL_TICKS = 64,
  localparam int CNT_W = $clog2(CELL_TICKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CELL_TICKS - 1);

  assign last_o = en_i && (cnt_o == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (last_o) cnt_o <= '0;
    else if (en_i)   cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rc_frame_shreg.sv
module rc_frame_shreg #(
  parameter int BYTE_W = 8,
  localparam int FRAME_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              msb_o
);
  logic [FRAME_W-1:0] sr_q;

  // command occupies the upper half so it leaves first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (load_i)   sr_q <= {cmd_i, data_i};
    else if (shift_i)  sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
  end

  assign msb_o = sr_q[FRAME_W-1];
endmodule

// File: rtl/rc_pwm_tx.sv
module rc_pwm_tx #(
  parameter int BYTE_W     = 8,
  parameter int CELL_TICKS = 64,
  parameter int GAP_CELLS  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              pulse_o,
  output logic              busy_o,
  output logic              done_o
);
  import rc_pwm_pkg::*;

  localparam int CNT_W      = $clog2(CELL_TICKS);
  localparam int BITS       = 2 * BYTE_W;
  localparam int MAX_CELLS  = (BITS > GAP_CELLS) ? BITS : GAP_CELLS;
  localparam int IDX_W      = $clog2(MAX_CELLS);
  localparam int PULSE_LONG = (CELL_TICKS * 7) / 8;
  localparam int PULSE_SHRT = CELL_TICKS / 8;
  localparam logic [CNT_W-1:0] LONG_C = CNT_W'(PULSE_LONG);
  localparam logic [CNT_W-1:0] SHRT_C = CNT_W'(PULSE_SHRT);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(BITS - 1);
  localparam logic [IDX_W-1:0] LAST_GAP = IDX_W'(GAP_CELLS - 1);

  tx_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt;
  logic             cell_last, accept, shift, cur_bit, gap_end, done_q;

  assign accept  = (state_q == ST_IDLE) && start_i;
  assign shift   = (state_q == ST_SEND) && cell_last;
  assign gap_end = (state_q == ST_GAP) && cell_last && (idx_q == LAST_GAP);

  rc_cell_timer #(.CELL_TICKS(CELL_TICKS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .en_i   (tick_i && (state_q != ST_IDLE)),
    .cnt_o  (cnt),
    .last_o (cell_last)
  );

  rc_frame_shreg #(.BYTE_W(BYTE_W)) u_shreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .shift_i (shift),
    .cmd_i   (cmd_i),
    .data_i  (data_i),
    .msb_o   (cur_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= gap_end;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_SEND;
          idx_q   <= '0;
        end
        ST_SEND: if (cell_last) begin
          if (idx_q == LAST_BIT) begin
            state_q <= ST_GAP;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_GAP: if (cell_last) begin
          if (idx_q == LAST_GAP) state_q <= ST_IDLE;
          else                   idx_q   <= idx_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // high phase leads each cell
  assign pulse_o = (state_q == ST_SEND) && (cnt < (cur_bit ? LONG_C : SHRT_C));
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
endmodule

// File: rtl/rc_pwm_tx_chk.sv
module rc_pwm_tx_chk #(
  parameter int CELL_TICKS = 64
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic start_i,
  input logic pulse_o,
  input logic busy_o,
  input logic done_o
);
  localparam int PULSE_LONG = (CELL_TICKS * 7) / 8;

  int unsigned hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               hi_cnt <= 0;
    else if (!pulse_o)         hi_cnt <= 0;
    else if (tick_i)           hi_cnt <= hi_cnt + 1;
  end

  assert_idle_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !pulse_o);
  assert_busy_needs_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  assert_done_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_rise_timing_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> ($past(tick_i) || $past(start_i)));
  assert_fall_timing_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_o) |-> $past(tick_i));
  assert_pulse_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_cnt <= PULSE_LONG);
endmodule

bind rc_pwm_tx rc_pwm_tx_chk #(.CELL_TICKS(CELL_TICKS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .start_i (start_i),
  .pulse_o (pulse_o),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/sim_rc_pwm_tx.sv
`timescale 1ns/1ps
module sim_rc_pwm_tx;
  localparam int TD   = 3;   // cycles per tick
  localparam int CELL = 64;
  localparam int GAP  = 8 * CELL;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, start = 1'b0;
  logic [7:0] cmd = '0, dat = '0;
  logic pulse, busy, done;

  int n_chk = 0, n_fail = 0;
  int exp_hi[$], exp_lo[$];
  bit finished = 0;

  always #2 clk = ~clk;

  rc_pwm_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start),
    .cmd_i(cmd), .data_i(dat), .pulse_o(pulse), .busy_o(busy), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // tick generator
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      tick = (ph == TD - 1);
      ph = (ph == TD - 1) ? 0 : ph + 1;
    end
  end

  // monitor: run lengths of high and low per cell, sampled before tick edges
  initial begin
    bit in_hi = 0, in_lo = 0, prev_busy = 0;
    int hi = 0, lo = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_busy && !busy)
          check(done === 1'b1, "R8 done at busy fall", int'(done), 1);
        prev_busy = busy;
        if (tick) begin
          if (pulse) begin
            if (in_lo) begin compare(hi, lo); in_lo = 0; end
            if (in_hi) hi++;
            else begin in_hi = 1; hi = 1; end
          end else if (busy) begin
            if (in_hi) begin in_hi = 0; in_lo = 1; lo = 1; end
            else if (in_lo) lo++;
          end else if (in_lo) begin
            compare(hi, lo); in_lo = 0;
          end
        end
      end
    end
  end

  // scoreboard compare; tick-granular run lengths also cover R9
  task automatic compare(input int hi, input int lo);
    int eh, el;
    if (exp_hi.size() == 0) begin
      check(0, "R7 unexpected cell", hi, 0);
      return;
    end
    eh = exp_hi.pop_front();
    el = exp_lo.pop_front();
    check(hi == eh, (eh == 56) ? "R3 high ticks" : "R4 high ticks", hi, eh);
    check(lo == el, (el > CELL) ? "R6 low+gap ticks" : "R5 low ticks", lo, el);
  endtask

  task automatic send(input logic [7:0] c, input logic [7:0] d);
    logic [15:0] fr;
    while (busy) @(negedge clk);
    fr = {c, d};
    cmd = c; dat = d; start = 1'b1;
    for (int k = 0; k < 16; k++) begin
      int h;
      h = fr[15-k] ? 56 : 8;
      exp_hi.push_back(h);
      exp_lo.push_back(CELL - h + ((k == 15) ? GAP : 0));
    end
    @(negedge clk);
    start = 1'b0;
    cmd = ~c; dat = ~d;  // R7: inputs change after capture
    check(busy === 1'b1, "R2 busy after start", int'(busy), 1);
    check(pulse === 1'b1, "R2 pulse after start", int'(pulse), 1);
  endtask

  task automatic poke(input logic [7:0] c, input logic [7:0] d);
    cmd = c; dat = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(pulse === 1'b0, "R1 pulse in reset", int'(pulse), 0);
    check(busy === 1'b0, "R1 busy in reset", int'(busy), 0);
    check(done === 1'b0, "R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pulse === 1'b0 && busy === 1'b0, "R1 idle after reset", int'({pulse, busy}), 0);

    send(8'hA5, 8'h3C);
    send(8'hFF, 8'h00);  // accepted in the done cycle (R8)
    repeat (200 * TD) @(negedge clk);
    poke(8'h12, 8'h34);  // R7: ignored mid-send
    repeat ((1024 + 100 - 201) * TD) @(negedge clk);
    check(busy === 1'b1, "R6 busy in gap", int'(busy), 1);
    check(pulse === 1'b0, "R6 pulse low in gap", int'(pulse), 0);
    poke(8'h56, 8'h78);  // R6: ignored in gap
    send(8'h00, 8'hFF);
    send(8'h81, 8'h7E);
    while (busy) @(negedge clk);
    repeat (10 * TD) @(negedge clk);
    check(exp_hi.size() == 0, "R5 all cells seen", exp_hi.size(), 0);
    check(done === 1'b0, "R8 done single cycle", int'(done), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule